// File: doc/BRIEF.md
# 6502 Effective Address Generator

This unit resolves the operand address of a 6502-family instruction once the opcode has been decoded. A decoder raises `start` for one cycle with an addressing-mode code, the PC of the first operand byte, the X and Y index values and a few qualifiers. The unit then reads operand bytes and pointer bytes through a byte-wide read port whose data returns one cycle after the request. It delivers the effective address, the PC to resume from and the number of extra cycles the instruction costs.

Pointer arithmetic matches the processor exactly. Zero-page pointers wrap inside page zero. The NMOS indirect jump fetches its high byte from the start of the same page when the pointer ends in 0xFF, and `cmosSel` selects the corrected CMOS behaviour instead. A `crossChk` qualifier picks between the page-cross-sensitive timing of an instruction and its constant timing. For the relative mode, `branchTaken` decides whether the computed target becomes the new PC.

Top module: `eff_addr_gen`

## Requirements
- R1: Mode codes are 0 imm, 1 zp, 2 zp+X, 3 zp+Y, 4 abs, 5 abs+X, 6 abs+Y, 7 (zp,X), 8 (zp)+Y, 9 (zp), 10 (abs), 11 (abs,X), 12 rel. For zp, zp+X and zp+Y the address is {0x00, (operand + index) mod 256}, so it never leaves page zero.
- R2: For (zp,X) the pointer sits at p = (operand + X) mod 256. The address is {byte[(p+1) mod 256], byte[p]}, so a pointer at 0xFF takes its high byte from 0x0000.
- R3: For (zp) the address is the little-endian word at the operand byte, with the high byte taken from (operand+1) mod 256. For (zp)+Y the same word plus Y in 16 bits is used. With `crossChk`=1, one extra cycle is reported when the sum's high byte differs from the word's high byte.
- R4: abs uses the little-endian 16-bit operand. abs+X and abs+Y add the index in 16 bits. With `crossChk`=1, one extra cycle is reported when the high byte of the sum differs from the high byte of the operand.
- R5: With `crossChk`=0, abs+X, abs+Y and (zp)+Y report zero extra cycles whatever the page.
- R6: For (abs) with `cmosSel`=0, the address is {byte[{hi, (lo+1) mod 256}], byte[{hi,lo}]}, so the high byte stays in the pointer's page. Zero extra cycles are reported.
- R7: For (abs) with `cmosSel`=1, the address is read from pointer and pointer+1 in 16 bits. One extra cycle is reported exactly when the pointer low byte is 0xFF.
- R8: For (abs,X), the pointer is the 16-bit operand plus X, and the address is the word at pointer and pointer+1.
- R9: For rel, the target is (PC+1) plus the sign-extended operand, and `effAddr` carries the target. If `branchTaken`=1, `pcOut` is the target and the extra count is 1, or 2 when the target page differs from the page of PC+1. If `branchTaken`=0, `pcOut` is PC+1 and the extra count is 0.
- R10: `pcOut` is PC+1 for imm, zp, zp+X, zp+Y, (zp,X), (zp)+Y and (zp). It is PC+2 for abs, abs+X, abs+Y, (abs) and (abs,X).
- R11: A read requested while `memRd` is high returns on `memData` in the next cycle. `done` is high for exactly one cycle. It rises on the Nth rising edge after the edge that accepts `start`, where N is 1 for imm and unused codes, 3 for zp, zp+X, zp+Y and rel, 4 for abs, abs+X and abs+Y, 6 for (zp,X), (zp)+Y and (zp), and 7 for (abs) and (abs,X).
- R12: imm returns the PC as the address with no memory read. Unused codes 13 to 15 return address 0, `pcOut` equal to the PC and zero extra cycles.
- R13: Synchronous active-high `rst` returns the unit to idle and clears `done`, `effAddr`, `pcOut`, `extraCyc` and `memRd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (accepted when idle) |
| modeSel | input | 4 | Addressing-mode code |
| pcIn | input | 16 | PC of the first operand byte |
| xIdx | input | 8 | X index value |
| yIdx | input | 8 | Y index value |
| cmosSel | input | 1 | 1 selects CMOS indirect-jump behaviour |
| crossChk | input | 1 | 1 selects page-cross-sensitive timing |
| branchTaken | input | 1 | Branch condition result for rel |
| memData | input | 8 | Read data, one cycle after the request |
| memAddr | output | 16 | Read address |
| memRd | output | 1 | Read request |
| done | output | 1 | One-cycle result strobe |
| effAddr | output | 16 | Effective address |
| pcOut | output | 16 | Updated PC |
| extraCyc | output | 2 | Extra cycle count, 0 to 2 |

## Verification
The assertions take two things for granted. First, `start` arrives only while the unit is idle or in its `done` cycle. Second, the memory answers every request with exactly one cycle of latency, so the latched mode and PC stay valid until the result is delivered. The stimulus holds to this: it raises `start` only after `done` has been seen, and it models memory as a registered 64 KiB array. Random modes, PCs, indices and qualifiers are mixed with directed cases that place pointers at 0xFF, put indexed sums across page edges and give branch offsets in both directions.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2 * BYTE_W;
  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] M_IMM   = 4'd0;
  localparam logic [MODE_W-1:0] M_ZP    = 4'd1;
  localparam logic [MODE_W-1:0] M_ZPX   = 4'd2;
  localparam logic [MODE_W-1:0] M_ZPY   = 4'd3;
  localparam logic [MODE_W-1:0] M_ABS   = 4'd4;
  localparam logic [MODE_W-1:0] M_ABSX  = 4'd5;
  localparam logic [MODE_W-1:0] M_ABSY  = 4'd6;
  localparam logic [MODE_W-1:0] M_INDX  = 4'd7;
  localparam logic [MODE_W-1:0] M_INDY  = 4'd8;
  localparam logic [MODE_W-1:0] M_IZP   = 4'd9;
  localparam logic [MODE_W-1:0] M_IABS  = 4'd10;
  localparam logic [MODE_W-1:0] M_IABSX = 4'd11;
  localparam logic [MODE_W-1:0] M_REL   = 4'd12;

  typedef enum logic [3:0] {
    S_IDLE, S_RDOP0, S_RDOP1, S_CAPOP0, S_CAPOP1, S_RDP0, S_RDP1, S_CAPP1, S_FIN
  } state_e;

  typedef enum logic [1:0] {A_OP0, A_OP1, A_P0, A_P1} addr_sel_e;

  typedef struct packed {
    logic      latch;
    logic      rd;
    addr_sel_e aSel;
    logic      capOpLo;
    logic      capOpHi;
    logic      capTgtLo;
    logic      capTgtHi;
    logic      finish;
  } strobe_t;

  function automatic logic isAbsFam(input logic [MODE_W-1:0] m);
    return (m == M_ABS) || (m == M_ABSX) || (m == M_ABSY) || (m == M_IABS) || (m == M_IABSX);
  endfunction

  function automatic logic isZpPtr(input logic [MODE_W-1:0] m);
    return (m == M_INDX) || (m == M_INDY) || (m == M_IZP);
  endfunction

  function automatic logic isAbsPtr(input logic [MODE_W-1:0] m);
    return (m == M_IABS) || (m == M_IABSX);
  endfunction

  function automatic logic isNoRead(input logic [MODE_W-1:0] m);
    return (m == M_IMM) || (m > M_REL);
  endfunction
endpackage

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] modeSel,
  input  logic [MODE_W-1:0] modeQ,
  output strobe_t           stb
);
  state_e st, nx;

  always_ff @(posedge clk) begin
    if (rst) st <= S_IDLE;
    else     st <= nx;
  end

  always_comb begin
    stb  = '0;
    nx   = st;
    case (st)
      S_IDLE: if (start) begin
        stb.latch = 1'b1;
        nx = isNoRead(modeSel) ? S_FIN : S_RDOP0;
      end
      S_RDOP0: begin
        stb.rd   = 1'b1;
        stb.aSel = A_OP0;
        nx = isAbsFam(modeQ) ? S_RDOP1 : S_CAPOP0;
      end
      S_RDOP1: begin
        stb.rd      = 1'b1;
        stb.aSel    = A_OP1;
        stb.capOpLo = 1'b1;
        nx = S_CAPOP1;
      end
      S_CAPOP0: begin
        stb.capOpLo = 1'b1;
        nx = isZpPtr(modeQ) ? S_RDP0 : S_FIN;
      end
      S_CAPOP1: begin
        stb.capOpHi = 1'b1;
        nx = isAbsPtr(modeQ) ? S_RDP0 : S_FIN;
      end
      S_RDP0: begin
        stb.rd   = 1'b1;
        stb.aSel = A_P0;
        nx = S_RDP1;
      end
      S_RDP1: begin
        stb.rd       = 1'b1;
        stb.aSel     = A_P1;
        stb.capTgtLo = 1'b1;
        nx = S_CAPP1;
      end
      S_CAPP1: begin
        stb.capTgtHi = 1'b1;
        nx = S_FIN;
      end
      S_FIN: begin
        stb.finish = 1'b1;
        nx = S_IDLE;
      end
      default: nx = S_IDLE;
    endcase
  end
endmodule

// File: rtl/eag_dpath.sv
module eag_dpath
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [MODE_W-1:0] modeSel,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [BYTE_W-1:0] xIdx,
  input  logic [BYTE_W-1:0] yIdx,
  input  logic              cmosSel,
  input  logic              crossChk,
  input  logic              branchTaken,
  input  logic [BYTE_W-1:0] memData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic [MODE_W-1:0] modeQ,
  output logic [ADDR_W-1:0] pcQ,
  output logic              cmosQ,
  output logic              done,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] pcOut,
  output logic [1:0]        extraCyc
);
  logic [BYTE_W-1:0] xQ, yQ, opLo, opHi, tgtLo, tgtHi;
  logic              crossQ, takenQ;
  logic [ADDR_W-1:0] opWord, tgtWord, ptr0, ptr1, pc1, pc2, relT, idxSum;
  logic [BYTE_W-1:0] zpx, zpy;
  logic [ADDR_W-1:0] eaNx, pcNx;
  logic [1:0]        extNx;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ <= '0; pcQ <= '0; xQ <= '0; yQ <= '0;
      cmosQ <= 1'b0; crossQ <= 1'b0; takenQ <= 1'b0;
      opLo <= '0; opHi <= '0; tgtLo <= '0; tgtHi <= '0;
    end else begin
      if (stb.latch) begin
        modeQ <= modeSel; pcQ <= pcIn; xQ <= xIdx; yQ <= yIdx;
        cmosQ <= cmosSel; crossQ <= crossChk; takenQ <= branchTaken;
      end
      if (stb.capOpLo)  opLo  <= memData;
      if (stb.capOpHi)  opHi  <= memData;
      if (stb.capTgtLo) tgtLo <= memData;
      if (stb.capTgtHi) tgtHi <= memData;
    end
  end

  assign opWord  = {opHi, opLo};
  assign tgtWord = {tgtHi, tgtLo};
  assign zpx     = opLo + xQ;
  assign zpy     = opLo + yQ;
  assign pc1     = pcQ + 16'd1;
  assign pc2     = pcQ + 16'd2;
  assign relT    = pc1 + {{BYTE_W{opLo[BYTE_W-1]}}, opLo};

  always_comb begin
    case (modeQ)
      M_INDX: begin
        ptr0 = {8'h00, zpx};
        ptr1 = {8'h00, zpx + 8'd1};
      end
      M_IABS: begin
        ptr0 = opWord;
        ptr1 = cmosQ ? opWord + 16'd1 : {opHi, opLo + 8'd1};
      end
      M_IABSX: begin
        ptr0 = opWord + {8'h00, xQ};
        ptr1 = ptr0 + 16'd1;
      end
      default: begin
        ptr0 = {8'h00, opLo};
        ptr1 = {8'h00, opLo + 8'd1};
      end
    endcase
  end

  always_comb begin
    case (stb.aSel)
      A_OP0:   memAddr = pcQ;
      A_OP1:   memAddr = pc1;
      A_P0:    memAddr = ptr0;
      default: memAddr = ptr1;
    endcase
  end
  assign memRd = stb.rd;

  always_comb begin
    eaNx   = '0;
    pcNx   = pc1;
    extNx  = 2'd0;
    idxSum = '0;
    case (modeQ)
      M_IMM:  eaNx = pcQ;
      M_ZP:   eaNx = {8'h00, opLo};
      M_ZPX:  eaNx = {8'h00, zpx};
      M_ZPY:  eaNx = {8'h00, zpy};
      M_ABS: begin
        eaNx = opWord; pcNx = pc2;
      end
      M_ABSX, M_ABSY: begin
        idxSum = opWord + {8'h00, (modeQ == M_ABSX) ? xQ : yQ};
        eaNx   = idxSum; pcNx = pc2;
        extNx  = {1'b0, crossQ && (idxSum[ADDR_W-1:BYTE_W] != opHi)};
      end
      M_INDX, M_IZP: eaNx = tgtWord;
      M_INDY: begin
        idxSum = tgtWord + {8'h00, yQ};
        eaNx   = idxSum;
        extNx  = {1'b0, crossQ && (idxSum[ADDR_W-1:BYTE_W] != tgtHi)};
      end
      M_IABS: begin
        eaNx = tgtWord; pcNx = pc2;
        extNx = {1'b0, cmosQ && (opLo == 8'hFF)};
      end
      M_IABSX: begin
        eaNx = tgtWord; pcNx = pc2;
      end
      M_REL: begin
        eaNx = relT;
        if (takenQ) begin
          pcNx  = relT;
          extNx = (relT[ADDR_W-1:BYTE_W] != pc1[ADDR_W-1:BYTE_W]) ? 2'd2 : 2'd1;
        end
      end
      default: pcNx = pcQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0; effAddr <= '0; pcOut <= '0; extraCyc <= '0;
    end else begin
      done <= stb.finish;
      if (stb.finish) begin
        effAddr  <= eaNx;
        pcOut    <= pcNx;
        extraCyc <= extNx;
      end
    end
  end
endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [3:0]  modeSel,
  input  logic [15:0] pcIn,
  input  logic [7:0]  xIdx,
  input  logic [7:0]  yIdx,
  input  logic        cmosSel,
  input  logic        crossChk,
  input  logic        branchTaken,
  input  logic [7:0]  memData,
  output logic [15:0] memAddr,
  output logic        memRd,
  output logic        done,
  output logic [15:0] effAddr,
  output logic [15:0] pcOut,
  output logic [1:0]  extraCyc
);
  strobe_t           stb;
  logic [MODE_W-1:0] modeQ;
  logic [ADDR_W-1:0] pcQ;
  logic              cmosQ;

  eag_ctrl ctrl_i (
    .clk(clk), .rst(rst), .start(start), .modeSel(modeSel), .modeQ(modeQ), .stb(stb)
  );

  eag_dpath dpath_i (
    .clk(clk), .rst(rst), .stb(stb), .modeSel(modeSel), .pcIn(pcIn),
    .xIdx(xIdx), .yIdx(yIdx), .cmosSel(cmosSel), .crossChk(crossChk),
    .branchTaken(branchTaken), .memData(memData), .memAddr(memAddr), .memRd(memRd),
    .modeQ(modeQ), .pcQ(pcQ), .cmosQ(cmosQ), .done(done), .effAddr(effAddr),
    .pcOut(pcOut), .extraCyc(extraCyc)
  );
endmodule

// File: rtl/eff_addr_gen_chk.sv
module eff_addr_gen_chk
  import eag_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        memRd,
  input logic [15:0] memAddr,
  input logic        done,
  input logic [15:0] effAddr,
  input logic [15:0] pcOut,
  input logic [1:0]  extraCyc,
  input logic [3:0]  modeQ,
  input logic [15:0] pcQ,
  input logic        cmosQ
);
  logic rstSeen = 1'b0;
  always_ff @(posedge clk) rstSeen <= rst;

  always_ff @(posedge clk) begin
    if (rstSeen && !rst) begin
      a_r13_reset_clears: assert (!done && !memRd && effAddr == '0 && pcOut == '0 && extraCyc == '0)
        else $error("R13 outputs not cleared by reset");
    end
  end

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  a_r11_idle_at_done: assert property (@(posedge clk) disable iff (rst) done |-> !memRd);
  a_r9_extra_range: assert property (@(posedge clk) disable iff (rst) done |-> extraCyc != 2'd3);
  a_r1_zp_page0: assert property (@(posedge clk) disable iff (rst)
    (done && (modeQ == M_ZP || modeQ == M_ZPX || modeQ == M_ZPY)) |-> effAddr[15:8] == 8'h00);
  a_r2_ptr_in_page0: assert property (@(posedge clk) disable iff (rst)
    (memRd && isZpPtr(modeQ) && memAddr != pcQ) |-> memAddr[15:8] == 8'h00);
  a_r10_abs_pc_step: assert property (@(posedge clk) disable iff (rst)
    (done && isAbsFam(modeQ)) |-> pcOut == pcQ + 16'd2);
  a_r6_nmos_no_extra: assert property (@(posedge clk) disable iff (rst)
    (done && modeQ == M_IABS && !cmosQ) |-> extraCyc == 2'd0);
  a_r12_unused_zero: assert property (@(posedge clk) disable iff (rst)
    (done && modeQ > M_REL) |-> (effAddr == '0 && pcOut == pcQ && extraCyc == 2'd0));
endmodule

bind eff_addr_gen eff_addr_gen_chk chk_i (
  .clk(clk), .rst(rst), .memRd(memRd), .memAddr(memAddr), .done(done),
  .effAddr(effAddr), .pcOut(pcOut), .extraCyc(extraCyc),
  .modeQ(modeQ), .pcQ(pcQ), .cmosQ(cmosQ)
);

// File: tb/eff_addr_gen_tb_top.sv
module eff_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  modeSel = '0;
  logic [15:0] pcIn = '0;
  logic [7:0]  xIdx = '0, yIdx = '0;
  logic        cmosSel = 1'b0, crossChk = 1'b0, branchTaken = 1'b0;
  logic [7:0]  memData = '0;
  logic [15:0] memAddr, effAddr, pcOut;
  logic        memRd, done;
  logic [1:0]  extraCyc;
  logic [7:0]  mem [0:65535];
  int nChk = 0, nFail = 0;

  always #5 clk = ~clk;

  eff_addr_gen dut_i (
    .clk(clk), .rst(rst), .start(start), .modeSel(modeSel), .pcIn(pcIn),
    .xIdx(xIdx), .yIdx(yIdx), .cmosSel(cmosSel), .crossChk(crossChk),
    .branchTaken(branchTaken), .memData(memData), .memAddr(memAddr), .memRd(memRd),
    .done(done), .effAddr(effAddr), .pcOut(pcOut), .extraCyc(extraCyc)
  );

  always @(posedge clk) if (memRd) memData <= mem[memAddr];

  task automatic chk(input string req, input string what, input int got, input int exp);
    nChk++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  endtask

  function automatic logic [15:0] rdw(input logic [15:0] lo, input logic [15:0] hi);
    return {mem[hi], mem[lo]};
  endfunction

  function automatic string tagOf(input logic [3:0] m, input logic cr, input logic cm);
    case (m)
      4'd1, 4'd2, 4'd3: return "R1";
      4'd4:             return "R4";
      4'd5, 4'd6:       return cr ? "R4" : "R5";
      4'd7:             return "R2";
      4'd8, 4'd9:       return "R3";
      4'd10:            return cm ? "R7" : "R6";
      4'd11:            return "R8";
      4'd12:            return "R9";
      default:          return "R12";
    endcase
  endfunction

  function automatic void refCalc(input logic [3:0] m, input logic [15:0] pc,
      input logic [7:0] x, input logic [7:0] y, input logic cm, input logic cr, input logic tk,
      output logic [15:0] ea, output logic [15:0] pn, output logic [1:0] ext, output int lat);
    logic [7:0]  op, p;
    logic [15:0] w, s, nxt;
    op = mem[pc]; w = {mem[pc + 16'd1], op};
    ea = '0; pn = pc + 16'd1; ext = 2'd0; lat = 3;
    case (m)
      4'd0: begin ea = pc; lat = 1; end
      4'd1: ea = {8'h00, op};
      4'd2: begin p = op + x; ea = {8'h00, p}; end
      4'd3: begin p = op + y; ea = {8'h00, p}; end
      4'd4: begin ea = w; pn = pc + 16'd2; lat = 4; end
      4'd5, 4'd6: begin
        s = w + {8'h00, (m == 4'd5) ? x : y};
        ea = s; pn = pc + 16'd2; lat = 4;
        ext = (cr && s[15:8] != w[15:8]) ? 2'd1 : 2'd0;
      end
      4'd7: begin p = op + x; ea = rdw({8'h00, p}, {8'h00, p + 8'd1}); lat = 6; end
      4'd8: begin
        w = rdw({8'h00, op}, {8'h00, op + 8'd1}); s = w + {8'h00, y};
        ea = s; lat = 6; ext = (cr && s[15:8] != w[15:8]) ? 2'd1 : 2'd0;
      end
      4'd9: begin ea = rdw({8'h00, op}, {8'h00, op + 8'd1}); lat = 6; end
      4'd10: begin
        pn = pc + 16'd2; lat = 7;
        if (cm) begin ea = rdw(w, w + 16'd1); ext = (w[7:0] == 8'hFF) ? 2'd1 : 2'd0; end
        else ea = rdw(w, {w[15:8], w[7:0] + 8'd1});
      end
      4'd11: begin s = w + {8'h00, x}; ea = rdw(s, s + 16'd1); pn = pc + 16'd2; lat = 7; end
      4'd12: begin
        nxt = pc + 16'd1; s = nxt + {{8{op[7]}}, op}; ea = s;
        if (tk) begin pn = s; ext = (s[15:8] != nxt[15:8]) ? 2'd2 : 2'd1; end
      end
      default: begin pn = pc; lat = 1; end
    endcase
  endfunction

  task automatic runOne(input logic [3:0] m, input logic [15:0] pc, input logic [7:0] x,
      input logic [7:0] y, input logic cm, input logic cr, input logic tk);
    logic [15:0] eEa, ePc;
    logic [1:0]  eExt;
    int eLat, k;
    string tg;
    refCalc(m, pc, x, y, cm, cr, tk, eEa, ePc, eExt, eLat);
    tg = tagOf(m, cr, cm);
    @(negedge clk);
    modeSel = m; pcIn = pc; xIdx = x; yIdx = y;
    cmosSel = cm; crossChk = cr; branchTaken = tk; start = 1'b1;
    @(negedge clk);
    start = 1'b0; k = 1;
    while (!done && k < 20) begin @(negedge clk); k++; end
    chk("R11", "latency", k, eLat + 1);
    chk(tg, "effAddr", int'(effAddr), int'(eEa));
    chk((m == 4'd12) ? "R9" : (m > 4'd12) ? "R12" : "R10", "pcOut", int'(pcOut), int'(ePc));
    chk(tg, "extraCyc", int'(extraCyc), int'(eExt));
    @(negedge clk);
    chk("R11", "done width", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R11 watchdog: got still running expected finished");
    finishRun();
  end

  initial begin
    process::self().srandom(32'h6502);
    for (int i = 0; i < 65536; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R13: state right after reset
    chk("R13", "done", int'(done), 0);
    chk("R13", "effAddr", int'(effAddr), 0);
    chk("R13", "pcOut", int'(pcOut), 0);
    chk("R13", "extraCyc", int'(extraCyc), 0);
    chk("R13", "memRd", int'(memRd), 0);

    // R1: zero-page index wraps within page zero
    mem[16'h0300] = 8'hF0;
    runOne(4'd2, 16'h0300, 8'h20, 8'h00, 1'b0, 1'b0, 1'b0);
    runOne(4'd3, 16'h0300, 8'h00, 8'h11, 1'b0, 1'b0, 1'b0);
    // R2: (zp,X) pointer at 0xFF
    mem[16'h0400] = 8'hFE; mem[16'h00FF] = 8'h34; mem[16'h0000] = 8'h12;
    runOne(4'd7, 16'h0400, 8'h01, 8'h00, 1'b0, 1'b0, 1'b0);
    // R3: (zp),Y and (zp) with pointer at 0xFF, page cross
    mem[16'h0500] = 8'hFF; mem[16'h00FF] = 8'hF0;
    runOne(4'd8, 16'h0500, 8'h00, 8'h20, 1'b0, 1'b1, 1'b0);
    runOne(4'd8, 16'h0500, 8'h00, 8'h20, 1'b0, 1'b0, 1'b0);
    runOne(4'd9, 16'h0500, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    // R6 / R7: indirect jump through 0x20FF
    mem[16'h0600] = 8'hFF; mem[16'h0601] = 8'h20;
    mem[16'h20FF] = 8'h78; mem[16'h2000] = 8'h56; mem[16'h2100] = 8'h9A;
    runOne(4'd10, 16'h0600, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    runOne(4'd10, 16'h0600, 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
    // R4 / R5: abs,X crossing a page, sensitive and constant
    mem[16'h0700] = 8'hF0; mem[16'h0701] = 8'h12;
    runOne(4'd5, 16'h0700, 8'h20, 8'h00, 1'b0, 1'b1, 1'b0);
    runOne(4'd5, 16'h0700, 8'h20, 8'h00, 1'b0, 1'b0, 1'b0);
    runOne(4'd6, 16'h0700, 8'h00, 8'h05, 1'b0, 1'b1, 1'b0);
    // R8: (abs,X)
    runOne(4'd11, 16'h0700, 8'h0F, 8'h00, 1'b0, 1'b0, 1'b0);
    // R9: branches across and within a page, backward, not taken
    mem[16'h10F0] = 8'h20;
    runOne(4'd12, 16'h10F0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
    runOne(4'd12, 16'h10F0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    mem[16'h10F0] = 8'h02;
    runOne(4'd12, 16'h10F0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
    mem[16'h10F0] = 8'h80;
    runOne(4'd12, 16'h10F0, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1);
    // R12: immediate and unused codes
    runOne(4'd0, 16'hFFFF, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
    runOne(4'd14, 16'h1234, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < 400; i++) begin
      runOne(4'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
             1'($urandom), 1'($urandom), 1'($urandom));
    end
    finishRun();
  end
endmodule